// File: doc/BRIEF.md
# Four-Operation Four-Bit ALU

This block is a purely combinational arithmetic/logic unit for two unsigned words of `WIDTH` bits (four by default). It offers four operations, add, subtract, bitwise AND and bitwise XOR, chosen by two select lines. It returns a result word and a carry-out.

The datapath is built only from 2:1 selector banks around one ripple-carry adder:

- **Arithmetic path.** The second operand or its bitwise inverse enters the adder. The subtract line steers that choice and also supplies the adder's carry-in, so a subtraction is formed as x + ~y + 1.
- **Logic path.** A second selector bank picks between the bitwise AND and the bitwise XOR of the operands.
- **Output.** A final bank chooses between the arithmetic and logic results. A one-bit selector gives the carry-out, which is the adder's carry in arithmetic mode and zero in logic mode.

The block holds no state. A surrounding pipeline registers its outputs where timing needs it.

Top module: `alu4_core`

## Requirements
- R1: With s1=0 and s0=0 (add), z equals (x + y) modulo 2^WIDTH and cout is the carry out of that unsigned sum.
- R2: With s1=0 and s0=1 (subtract), z equals (x - y) modulo 2^WIDTH, computed as x + ~y + 1.
- R3: In subtract mode (s1=0, s0=1), cout is 1 exactly when x >= y as unsigned values, and 0 when x < y.
- R4: With s1=1 and s0=0, z equals the bitwise AND of x and y.
- R5: With s1=1 and s0=1, z equals the bitwise XOR of x and y.
- R6: Whenever s1=1 (either logic operation), cout is 0 for every operand pair.
- R7: The outputs depend only on the present inputs. The same inputs give the same z and cout whatever operation or operands were applied before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | WIDTH | First operand |
| y | input | WIDTH | Second operand |
| s1 | input | 1 | Section select: 0 arithmetic, 1 logic |
| s0 | input | 1 | Operation select: add/AND when 0, subtract/XOR when 1 |
| z | output | WIDTH | Result word |
| cout | output | 1 | Adder carry-out in arithmetic mode, 0 in logic mode |

## Verification
All 256 operand pairs are applied under each of the four select codes.

- **Add.** The sweep tells a correct carry chain from one that drops or misroutes a carry, because every carry pattern appears.
- **Subtract.** The sweep separates a working carry-in injection and operand inversion from a missing one, since x = y and x = y + 1 are both covered.
- **Borrow boundary.** The x >= y edge is probed directly with 0 - 1, 15 - 15 and 15 - 0.
- **Logic operations.** Complementary bit patterns such as 1010/0101 show whether AND and XOR are swapped.
- **Logic carry.** A logic operation on all-ones operands exposes a carry leaking into logic mode.
- **State independence.** The same vector is reapplied after different operations to expose any hidden state.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
  // Select encoding {s1, s0}
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_AND = 2'b10,
    OP_XOR = 2'b11
  } alu_op_e;
endpackage

// File: rtl/alu4_mux2_bank.sv
module alu4_mux2_bank #(
  parameter int WIDTH = 4
) (
  input  logic             sel,
  input  logic [WIDTH-1:0] in0,
  input  logic [WIDTH-1:0] in1,
  output logic [WIDTH-1:0] out
);
  // one 2:1 selector per bit
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign out[i] = sel ? in1[i] : in0[i];
  end
endmodule

// File: rtl/alu4_ripple_adder.sv
module alu4_ripple_adder #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  logic [WIDTH:0] carry;

  assign carry[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_fa
    logic half;
    assign half         = a[i] ^ b[i];
    assign sum[i]       = half ^ carry[i];
    assign carry[i + 1] = (a[i] & b[i]) | (half & carry[i]);
  end

  assign cout = carry[WIDTH];
endmodule

// File: rtl/alu4_core.sv
module alu4_core #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             s1,
  input  logic             s0,
  output logic [WIDTH-1:0] z,
  output logic             cout
);
  logic [WIDTH-1:0] y_inv;
  logic [WIDTH-1:0] y_eff;
  logic [WIDTH-1:0] arith_res;
  logic             arith_carry;
  logic [WIDTH-1:0] and_res;
  logic [WIDTH-1:0] xor_res;
  logic [WIDTH-1:0] logic_res;
  logic [0:0]       carry_sel;

  assign y_inv   = ~y;
  assign and_res = x & y;
  assign xor_res = x ^ y;

  // operand steering: y or ~y, controlled by the subtract line
  alu4_mux2_bank #(.WIDTH(WIDTH)) u_ysel (
    .sel(s0), .in0(y), .in1(y_inv), .out(y_eff)
  );

  // single adder; subtract line doubles as carry-in
  alu4_ripple_adder #(.WIDTH(WIDTH)) u_add (
    .a(x), .b(y_eff), .cin(s0), .sum(arith_res), .cout(arith_carry)
  );

  // logic section: AND or XOR
  alu4_mux2_bank #(.WIDTH(WIDTH)) u_lsel (
    .sel(s0), .in0(and_res), .in1(xor_res), .out(logic_res)
  );

  // result selector: arithmetic or logic
  alu4_mux2_bank #(.WIDTH(WIDTH)) u_osel (
    .sel(s1), .in0(arith_res), .in1(logic_res), .out(z)
  );

  // carry selector: adder carry or forced zero
  alu4_mux2_bank #(.WIDTH(1)) u_csel (
    .sel(s1), .in0(arith_carry), .in1(1'b0), .out(carry_sel)
  );

  assign cout = carry_sel[0];
endmodule

// File: rtl/alu4_core_chk.sv
module alu4_core_chk #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] x,
  input logic [WIDTH-1:0] y,
  input logic             s1,
  input logic             s0,
  input logic [WIDTH-1:0] z,
  input logic             cout
);
  logic [WIDTH:0] wide_sum;
  logic [WIDTH:0] wide_dif;

  assign wide_sum = {1'b0, x} + {1'b0, y};
  assign wide_dif = {1'b0, x} - {1'b0, y};

  always_comb begin
    if (!s1 && !s0) begin
      a_r1_add_result : assert ({cout, z} == wide_sum);
    end
    if (!s1 && s0) begin
      a_r2_sub_result : assert (z == wide_dif[WIDTH-1:0]);
      a_r3_sub_carry  : assert (cout == (x >= y));
    end
    if (s1 && !s0) begin
      a_r4_and_result : assert (z == (x & y));
    end
    if (s1 && s0) begin
      a_r5_xor_result : assert (z == (x ^ y));
    end
    if (s1) begin
      a_r6_logic_cout : assert (cout == 1'b0);
    end
  end
endmodule

bind alu4_core alu4_core_chk #(.WIDTH(WIDTH)) u_chk (
  .x(x), .y(y), .s1(s1), .s0(s0), .z(z), .cout(cout)
);

// File: tb/alu4_core_tb.sv
`timescale 1ns/1ps
module alu4_core_tb;
  import alu4_pkg::*;

  localparam int W = 4;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] x, y;
  logic         s1, s0;
  logic [W-1:0] z;
  logic         cout;
  int           n_run, n_fail;
  bit           done;

  alu4_core #(.WIDTH(W)) u_dut (
    .x(x), .y(y), .s1(s1), .s0(s0), .z(z), .cout(cout)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s x=%0d y=%0d op=%0d%0d actual=%0d expected=%0d",
               req, x, y, s1, s0, got, exp);
    end
  endtask

  // behavioural reference: integer arithmetic, one vector per clock
  task automatic apply(input alu_op_e op, input int a, input int b);
    int ez, ec;
    @(posedge clk);
    x  = W'(a);
    y  = W'(b);
    {s1, s0} = op;
    case (op)
      OP_ADD: begin ez = (a + b) % 16; ec = (a + b) / 16; end
      OP_SUB: begin ez = (a - b + 16) % 16; ec = (a >= b) ? 1 : 0; end
      OP_AND: begin ez = a & b; ec = 0; end
      default: begin ez = a ^ b; ec = 0; end
    endcase
    @(negedge clk);
    case (op)
      OP_ADD: begin check("R1 z", int'(z), ez); check("R1 cout", int'(cout), ec); end
      OP_SUB: begin check("R2 z", int'(z), ez); check("R3 cout", int'(cout), ec); end
      OP_AND: begin check("R4 z", int'(z), ez); check("R6 cout", int'(cout), ec); end
      default: begin check("R5 z", int'(z), ez); check("R6 cout", int'(cout), ec); end
    endcase
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 0;
    rst_n = 1'b0;
    x = '0; y = '0; s1 = 1'b0; s0 = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // idle inputs: 0 + 0
    check("R1 idle z", int'(z), 0);
    check("R1 idle cout", int'(cout), 0);

    // boundary cases
    apply(OP_ADD, 15, 1);   // R1 wrap, carry 1
    apply(OP_SUB, 0, 1);    // R3 x<y: z=15, cout 0
    apply(OP_SUB, 15, 15);  // R3 equal: z=0, cout 1
    apply(OP_SUB, 15, 0);   // R3 z=15, cout 1
    apply(OP_AND, 10, 5);   // R4 disjoint bits -> 0
    apply(OP_XOR, 10, 5);   // R5 -> 15
    apply(OP_AND, 15, 15);  // R6 cout 0 with all ones
    apply(OP_XOR, 15, 15);

    // R7: identical vector after different history
    apply(OP_ADD, 9, 9);
    apply(OP_SUB, 3, 12);
    apply(OP_ADD, 9, 9);
    apply(OP_XOR, 6, 6);
    apply(OP_ADD, 9, 9);
    check("R7 repeat z", int'(z), 2);
    check("R7 repeat cout", int'(cout), 1);

    // exhaustive sweep of every operation and operand pair
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          apply(alu_op_e'(op), a, b);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200us;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule